// File: doc/BRIEF.md
# Byte-Wide SPI Port with Delayed Completion Status

This block is a byte-wide serial peripheral port that runs either as the clock-generating master or as a slave clocked from its pin. A small register interface sets it up and moves data. Writing the data register loads the transmit shift register. In master mode, that write also starts an 8-bit exchange, most significant bit first. The serial clock comes from a fixed divider of the system clock. In slave mode the port follows edges on its clock input, after a synchronizer. When a byte has fully arrived, it moves into a receive buffer and a buffer-full flag is raised.

A completion status output rises only after a selectable number of system clocks (8, 16, 24 or 32) has passed since a transfer ended. It falls when the next transfer begins. The clock and data-out pins are each modelled as a value plus an output enable. A per-pin control bit turns either pin into an open-drain driver, which pulls low and releases for high.

A slave that finishes a new byte while the previous one is still unread keeps the old byte and raises a sticky overflow flag. The newly shifted byte is lost.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) read 0x00. The status output is 0, and both pin output enables are 0.
- R2: In master mode (control bit 4 = 1) with the port enabled (control bit 6 = 1), a write to the data register (address 2) while idle starts a transfer. The transfer has 16 clock-pin toggles, each HALF_DIV system clocks apart, sends bit 7 first, and ends HALF_DIV*16 clocks after the write edge. The received byte is then readable at address 2.
- R3: With edge select (control bit 7) = 0, the clock idles low, data out changes on the rising edge and input is sampled on the falling edge. With edge select = 1, the clock idles high and both edges swap roles.
- R4: With a pin's open-drain bit set (status bit 3 for data out, status bit 2 for clock), that pin's output value is 0 and its enable is the inverse of the wanted level. With the bit clear, the enable is 1 and the value is the wanted level while the pin is driven.
- R5: The buffer-full flag (status bit 0) is set when a completed byte enters the receive buffer. A read of address 2 clears it. A read in the same cycle as a completion returns the old byte and leaves the flag set, with the new byte in the buffer.
- R6: In slave mode (control bit 4 = 0), a completion while the buffer-full flag is set and no read is under way sets the overflow flag (control bit 5) and leaves the buffer unchanged. A master completion never sets the overflow flag.
- R7: Writing control bit 5 as 0 clears the overflow flag. Writing it as 1 leaves the flag unchanged.
- R8: The status output rises exactly (S+1)*8 system clocks after the completion edge, where S is status bits 6:5. It falls at the edge that starts the next transfer.
- R9: With the port disabled (control bit 6 = 0), a data write starts nothing. Both pin output enables stay 0 and the clock pin does not toggle.
- R10: Control bits 3:0 and status bits 7, 4 and 1 read as 0 whatever is written to them.
- R11: In slave mode the port shifts on edges of the clock input, after a SYNC_STAGES-flop synchronizer. It sends the loaded byte bit 7 first and assembles the input byte per R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sck_i | input | 1 | Serial clock input used in slave mode |
| sck_o | output | 1 | Serial clock pin output value |
| sck_oe | output | 1 | Serial clock pin output enable |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data-out pin output value |
| sdo_oe | output | 1 | Serial data-out pin output enable |
| status_o | output | 1 | Delayed transfer-complete status |

## Verification
The register read that empties the receive buffer can land in the same cycle as the completion edge that refills it. The bench provokes this in master mode, where the completion edge is exactly 16*HALF_DIV clocks after the starting write. It raises the read strobe for that one edge and expects three things: the read returns the earlier byte, the buffer-full flag stays at 1, and the data register then holds the new byte with no overflow. The overflow set and its clear-by-write are judged separately on a slave that receives two bytes without a read in between.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // control register bit positions
    localparam int C_EDGE   = 7;
    localparam int C_EN     = 6;
    localparam int C_OVF    = 5;
    localparam int C_MASTER = 4;
    // status register bit positions
    localparam int S_DLY_HI = 6;
    localparam int S_DLY_LO = 5;
    localparam int S_OD_SDO = 3;
    localparam int S_OD_SCK = 2;
    localparam int S_RBF    = 0;

    typedef struct packed {
        logic              edge_sel;
        logic              en;
        logic              ovf;
        logic              master;
        logic [1:0]        dly;
        logic              od_sdo;
        logic              od_sck;
        logic              rbf;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] sh;
        logic              sdo_bit;
    } port_state_t;

endpackage

// File: rtl/spi_od_pad.sv
module spi_od_pad (
    input  logic drive,
    input  logic od,
    input  logic val,
    output logic pad_o,
    output logic pad_oe
);
    always_comb begin
        pad_o  = od ? 1'b0 : val;
        pad_oe = drive & (od ? ~val : 1'b1);
    end
endmodule

// File: rtl/spi_mclk.sv
module spi_mclk #(
    parameter int HALF_DIV = 2,
    parameter int NBITS    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic idle_lvl,
    input  logic start,
    output logic sck,
    output logic busy,
    output logic lead,
    output logic trail,
    output logic last
);
    localparam int CW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int TOG_W = $clog2(2 * NBITS);

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic [CW-1:0]    div;
        logic [TOG_W-1:0] tog;
    } mclk_t;

    mclk_t q, d;
    logic  fire;

    always_comb begin
        d     = q;
        fire  = q.busy && (q.div == CW'(HALF_DIV - 1));
        lead  = fire && !q.tog[0];
        trail = fire && q.tog[0];
        last  = trail && (q.tog == TOG_W'(2 * NBITS - 1));
        if (q.busy) begin
            d.div = fire ? '0 : q.div + 1'b1;
            if (fire) begin
                d.sck = ~q.sck;
                d.tog = q.tog + 1'b1;
            end
            if (last) d.busy = 1'b0;
        end
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.div  = '0;
            d.tog  = '0;
            d.sck  = idle_lvl;
        end
        if (!en) begin
            d.busy = 1'b0;
            d.div  = '0;
            d.tog  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.busy ? q.sck : idle_lvl;
    assign busy = q.busy;
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int NBITS       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic edge_sel,
    input  logic sck_i,
    input  logic sdi_i,
    output logic start,
    output logic lead,
    output logic trail,
    output logic last,
    output logic busy,
    output logic sdi_s
);
    localparam int BW = $clog2(NBITS);

    typedef struct packed {
        logic [SYNC_STAGES:0]   sck_p;
        logic [SYNC_STAGES-1:0] sdi_p;
        logic                   busy;
        logic [BW-1:0]          bits;
    } ssync_t;

    ssync_t q, d;
    logic   rise, fall, lead_raw, trail_raw;

    always_comb begin
        d       = q;
        d.sck_p = {q.sck_p[SYNC_STAGES-1:0], sck_i};
        d.sdi_p = {q.sdi_p[SYNC_STAGES-2:0], sdi_i};
        rise      = q.sck_p[SYNC_STAGES-1] & ~q.sck_p[SYNC_STAGES];
        fall      = ~q.sck_p[SYNC_STAGES-1] & q.sck_p[SYNC_STAGES];
        lead_raw  = edge_sel ? fall : rise;
        trail_raw = edge_sel ? rise : fall;
        lead  = en && lead_raw;
        trail = en && q.busy && trail_raw;
        last  = trail && (q.bits == BW'(NBITS - 1));
        start = lead && !q.busy;
        if (start) d.busy = 1'b1;
        if (trail) d.bits = q.bits + 1'b1;
        if (last) begin
            d.busy = 1'b0;
            d.bits = '0;
        end
        if (!en) begin
            d.busy = 1'b0;
            d.bits = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy  = q.busy;
    assign sdi_s = q.sdi_p[SYNC_STAGES-1];
endmodule

// File: rtl/spi_stat_delay.sv
module spi_stat_delay #(
    parameter int DLY_UNIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  logic       start,
    input  logic [1:0] sel,
    output logic       status
);
    localparam int CNT_W = $clog2(4 * DLY_UNIT);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             stat;
    } sdly_t;

    sdly_t            q, d;
    logic [CNT_W-1:0] load;

    always_comb begin
        d    = q;
        load = CNT_W'((int'(sel) + 1) * DLY_UNIT - 1);
        if (q.armed) begin
            if (q.cnt == '0) begin
                d.stat  = 1'b1;
                d.armed = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
        if (done) begin
            d.armed = 1'b1;
            d.cnt   = load;
            d.stat  = 1'b0;
        end
        if (start) begin
            d.armed = 1'b0;
            d.stat  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status = q.stat;
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DLY_UNIT    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       sdi_i,
    output logic       sdo_o,
    output logic       sdo_oe,
    output logic       status_o
);
    port_state_t q, d;

    logic wr_ctrl, wr_stat, wr_data, rd_data, ovf_clr;
    logic m_start, m_sck, m_busy, m_lead, m_trail, m_last;
    logic s_start, s_lead, s_trail, s_last, s_busy, s_sdi;
    logic busy_w, lead_w, trail_w, done_w, start_w, sdi_bit;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr_e'(reg_addr) == ADDR_CTRL);
        wr_stat = reg_wr && (reg_addr_e'(reg_addr) == ADDR_STAT);
        wr_data = reg_wr && (reg_addr_e'(reg_addr) == ADDR_DATA);
        rd_data = reg_rd && (reg_addr_e'(reg_addr) == ADDR_DATA);
        ovf_clr = wr_ctrl && !reg_wdata[C_OVF];
        m_start = wr_data && q.en && q.master && !m_busy;
    end

    spi_mclk #(.HALF_DIV(HALF_DIV), .NBITS(BYTE_W)) u_mclk (
        .clk(clk), .rst_n(rst_n), .en(q.en && q.master), .idle_lvl(q.edge_sel),
        .start(m_start), .sck(m_sck), .busy(m_busy), .lead(m_lead),
        .trail(m_trail), .last(m_last)
    );

    spi_slave_sync #(.SYNC_STAGES(SYNC_STAGES), .NBITS(BYTE_W)) u_ssync (
        .clk(clk), .rst_n(rst_n), .en(q.en && !q.master), .edge_sel(q.edge_sel),
        .sck_i(sck_i), .sdi_i(sdi_i), .start(s_start), .lead(s_lead),
        .trail(s_trail), .last(s_last), .busy(s_busy), .sdi_s(s_sdi)
    );

    always_comb begin
        busy_w  = q.master ? m_busy  : s_busy;
        lead_w  = q.master ? m_lead  : s_lead;
        trail_w = q.master ? m_trail : s_trail;
        done_w  = q.master ? m_last  : s_last;
        start_w = q.master ? m_start : s_start;
        sdi_bit = q.master ? sdi_i   : s_sdi;
    end

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.edge_sel = reg_wdata[C_EDGE];
            d.en       = reg_wdata[C_EN];
            d.master   = reg_wdata[C_MASTER];
            if (!reg_wdata[C_OVF]) d.ovf = 1'b0;
        end
        if (wr_stat) begin
            d.dly    = reg_wdata[S_DLY_HI:S_DLY_LO];
            d.od_sdo = reg_wdata[S_OD_SDO];
            d.od_sck = reg_wdata[S_OD_SCK];
        end
        if (wr_data && !busy_w) d.sh = reg_wdata;
        if (lead_w)  d.sdo_bit = q.sh[BYTE_W-1];
        if (trail_w) d.sh = {q.sh[BYTE_W-2:0], sdi_bit};
        if (rd_data) d.rbf = 1'b0;
        if (done_w) begin
            if (!q.master && q.rbf && !rd_data) begin
                d.ovf = 1'b1;
            end else begin
                d.rx  = {q.sh[BYTE_W-2:0], sdi_bit};
                d.rbf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            ADDR_CTRL: reg_rdata = {q.edge_sel, q.en, q.ovf, q.master, 4'b0000};
            ADDR_STAT: reg_rdata = {1'b0, q.dly, 1'b0, q.od_sdo, q.od_sck, 1'b0, q.rbf};
            ADDR_DATA: reg_rdata = q.rx;
            default:   reg_rdata = 8'h00;
        endcase
    end

    spi_od_pad u_sck_pad (
        .drive(q.en && q.master), .od(q.od_sck), .val(m_sck),
        .pad_o(sck_o), .pad_oe(sck_oe)
    );

    spi_od_pad u_sdo_pad (
        .drive(q.en), .od(q.od_sdo), .val(q.sdo_bit),
        .pad_o(sdo_o), .pad_oe(sdo_oe)
    );

    spi_stat_delay #(.DLY_UNIT(DLY_UNIT)) u_sdly (
        .clk(clk), .rst_n(rst_n), .done(done_w), .start(start_w),
        .sel(q.dly), .status(status_o)
    );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic master,
    input logic en,
    input logic edge_sel,
    input logic od_sdo,
    input logic od_sck,
    input logic rbf,
    input logic ovf,
    input logic ovf_clr,
    input logic status_o,
    input logic sck_o,
    input logic sck_oe,
    input logic sdo_o,
    input logic sdo_oe
);
    a_r4_sdo_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        (od_sdo && sdo_oe) |-> !sdo_o);

    a_r4_sck_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        (od_sck && sck_oe) |-> !sck_o);

    a_r3_sck_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !busy && !od_sck) |-> (sck_oe && sck_o == edge_sel));

    a_r5_rbf_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rbf);

    a_r6_no_master_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done && master) |=> !$rose(ovf));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    a_r8_status_drop_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !status_o);

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!sck_oe && !sdo_oe));
endmodule

bind spi_port spi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .done(done_w),
    .master(q.master), .en(q.en), .edge_sel(q.edge_sel),
    .od_sdo(q.od_sdo), .od_sck(q.od_sck), .rbf(q.rbf), .ovf(q.ovf),
    .ovf_clr(ovf_clr), .status_o(status_o), .sck_o(sck_o), .sck_oe(sck_oe),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int SH         = 8;   // bench half period when driving a slave

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sck_o, sck_oe, sdo_o, sdo_oe, status_o;
    logic       sck_drv = 1'b0, sdi_drv = 1'b0, loop = 1'b0;
    logic       sdo_line, sck_line, sdi_i;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    assign sdo_line = sdo_oe ? sdo_o : 1'b1;
    assign sck_line = sck_oe ? sck_o : 1'b1;
    assign sdi_i    = loop ? sdo_line : sdi_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_port #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_i(sck_drv), .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi_i),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe), .status_o(status_o)
    );

    // {edge, od_sdo, od_sck, dly[1:0], data[7:0]}
    localparam logic [12:0] VECS [0:5] = '{
        {1'b0, 1'b0, 1'b0, 2'd0, 8'hA5},
        {1'b1, 1'b0, 1'b0, 2'd1, 8'h3C},
        {1'b0, 1'b1, 1'b0, 2'd2, 8'h81},
        {1'b1, 1'b0, 1'b1, 2'd3, 8'h7E},
        {1'b0, 1'b1, 1'b1, 2'd1, 8'h00},
        {1'b1, 1'b1, 1'b1, 2'd0, 8'hFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic slave_xfer(input logic [7:0] mosi, input logic edge_sel, output logic [7:0] miso);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sck_drv = ~edge_sel; sdi_drv = mosi[i];
            repeat (SH) @(negedge clk);
            miso[i] = sdo_line;
            sck_drv = edge_sel;
            repeat (SH - 1) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, miso;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
        peek(2'd1, v); chk("R1 stat reset", v, 8'h00);
        chk("R1 status_o reset", status_o, 1'b0);
        chk("R1 pin enables reset", {sck_oe, sdo_oe}, 2'b00);

        // R10 reserved bits
        reg_write(2'd0, 8'h0F); peek(2'd0, v); chk("R10 ctrl reserved", v, 8'h00);
        reg_write(2'd1, 8'h92); peek(2'd1, v); chk("R10 stat reserved", v, 8'h00);
        // R7 writing 1 to overflow does not set it; R10 low bits stay 0
        reg_write(2'd0, 8'hFF); peek(2'd0, v); chk("R7 ovf write-1 no set", v, 8'hD0);
        reg_write(2'd0, 8'h00);

        // R9 disabled master: no transfer
        reg_write(2'd0, 8'h10);
        reg_write(2'd2, 8'hA5);
        begin
            int tg = 0;
            logic prev = sck_line;
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (sck_line != prev) tg++;
                prev = sck_line;
            end
            chk("R9 no sck toggle", tg, 0);
        end
        peek(2'd1, v); chk("R9 rbf stays 0", v[0], 1'b0);
        chk("R9 pins released", {sck_oe, sdo_oe}, 2'b00);

        // master vectors with loopback
        loop = 1'b1;
        for (int n = 0; n < 6; n++) begin
            logic       e, osd, osk;
            logic [1:0] dl;
            logic [7:0] dat;
            int         k, tg, s;
            logic       prev;
            {e, osd, osk, dl, dat} = VECS[n];
            reg_write(2'd1, {1'b0, dl, 1'b0, osd, osk, 2'b00});
            reg_write(2'd0, {e, 1'b1, 1'b0, 1'b1, 4'b0000});
            @(negedge clk);
            chk("R3 sck idle level", sck_line, e);
            chk("R4 sck pin encoding", {sck_oe, sck_o}, osk ? {~e, 1'b0} : {1'b1, e});
            reg_write(2'd2, dat);
            chk("R8 status low after start", status_o, 1'b0);
            k = 0; tg = 0; prev = sck_line;
            peek(2'd1, v);
            while (!v[0] && k < 400) begin
                @(negedge clk);
                k++;
                if (sck_line != prev) tg++;
                prev = sck_line;
                peek(2'd1, v);
            end
            chk("R2 completion time", k, 16 * HALF);
            chk("R2 sck toggles", tg, 16);
            s = 0;
            while (!status_o && s < 100) begin
                @(negedge clk);
                s++;
            end
            chk("R8 status delay", s, (int'(dl) + 1) * 8);
            chk("R3 sck back to idle", sck_line, e);
            reg_read(2'd2, v); chk("R2 loopback byte", v, dat);
            peek(2'd1, v); chk("R5 rbf cleared by read", v[0], 1'b0);
        end

        // R5 coincident read and completion (master)
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h50);
        reg_write(2'd2, 8'h81);
        repeat (16 * HALF + 4) @(negedge clk);
        peek(2'd1, v); chk("R5 rbf set", v[0], 1'b1);
        @(negedge clk);
        reg_addr = 2'd2; reg_wdata = 8'h3C; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (16 * HALF - 1) @(negedge clk);
        reg_addr = 2'd2; reg_rd = 1'b1;
        #1 v = reg_rdata;
        chk("R5 coincident read old byte", v, 8'h81);
        @(negedge clk);
        reg_rd = 1'b0;
        peek(2'd1, v); chk("R5 rbf kept on coincident read", v[0], 1'b1);
        peek(2'd0, v); chk("R6 no master overflow", v[5], 1'b0);
        peek(2'd2, v); chk("R5 new byte stored", v, 8'h3C);
        reg_read(2'd2, v);
        loop = 1'b0;

        // slave mode, edge select 1
        reg_write(2'd0, 8'h00);
        sck_drv = 1'b1;
        repeat (4) @(negedge clk);
        reg_write(2'd0, 8'hC0);
        chk("R4 slave sck not driven", sck_oe, 1'b0);
        reg_write(2'd2, 8'hC3);
        slave_xfer(8'h5A, 1'b1, miso);
        chk("R11 slave sends MSB first e1", miso, 8'hC3);
        peek(2'd1, v); chk("R5 slave rbf set", v[0], 1'b1);
        reg_read(2'd2, v); chk("R11 slave received e1", v, 8'h5A);

        // slave mode, edge select 0, then overflow
        reg_write(2'd0, 8'h00);
        sck_drv = 1'b0;
        repeat (4) @(negedge clk);
        reg_write(2'd0, 8'h40);
        reg_write(2'd2, 8'h96);
        slave_xfer(8'h2D, 1'b0, miso);
        chk("R11 slave sends MSB first e0", miso, 8'h96);
        peek(2'd2, v); chk("R11 slave received e0", v, 8'h2D);
        reg_write(2'd2, 8'h11);
        slave_xfer(8'hE7, 1'b0, miso);
        peek(2'd0, v); chk("R6 slave overflow set", v[5], 1'b1);
        peek(2'd2, v); chk("R6 buffer keeps old byte", v, 8'h2D);
        reg_write(2'd0, 8'h60);
        peek(2'd0, v); chk("R7 ovf kept on write 1", v[5], 1'b1);
        reg_write(2'd0, 8'h40);
        peek(2'd0, v); chk("R7 ovf cleared on write 0", v[5], 1'b0);
        reg_read(2'd2, v);
        peek(2'd1, v); chk("R5 slave rbf cleared", v[0], 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule